// File: doc/BRIEF.md
# Power-Management Command Port with SMI Request

This block sits behind a small byte-wide register bus and gives software one command byte through which it either flips the platform between the legacy SMI-driven power-management mode and the SCI-driven mode, or asks for a system-management interrupt. Two reserved command values, 0xF1 and 0xF0, only enter and leave the SCI mode. Every other value is treated as an APM-style request: it produces a single-cycle `smi_pulse`, but only when the SMI enable register allows it.

The SMI enable register carries a global-enable bit (bit 0) and a command-enable bit (bit 5). The other six bits are plain storage. An eight-byte PM control range holds a write-once lock in bit 4 of its first byte. After the lock is set, it cannot be cleared by software, and bit 0 of the SMI enable register is frozen. Only reset releases the lock. Every register can be read back through a combinational read port.

The command unit has two state machines. The pulse machine has states IDLE and FIRE. IDLE moves to FIRE on a gated non-reserved command write. FIRE returns to IDLE, or stays in FIRE if another gated command is written. The mode machine has states SMI_MODE and SCI_MODE. Code 0xF1 moves it from SMI_MODE to SCI_MODE, and code 0xF0 moves it back. The lock machine has states OPEN and SHUT. It moves from OPEN to SHUT when a write to the control range leaves byte 0 bit 4 set. It has no exit except reset.

Top module: `pmc_smi_port`

## Requirements
- R1: While reset is applied and after reset, `sci_en` and `smi_pulse` are 0 and every register reads 0, including the lock.
- R2: Writing 0xF1 to the command address (0x0) makes `sci_en` read 1 from the next cycle. Writing 0xF0 makes it read 0. Other codes leave it unchanged.
- R3: A command write of 0xF0 or 0xF1 never raises `smi_pulse`, whatever the enables hold.
- R4: A command write of any other code, while SMI enable bits 0 and 5 are both 1, raises `smi_pulse` for exactly the one cycle after the write.
- R5: No `smi_pulse` follows a non-reserved command write when SMI enable bit 0 or bit 5 is 0.
- R6: Writing the first control byte (address 0x8) with bit 4 set engages the lock from the next cycle. After that, bit 4 of address 0x8 reads 1 and cannot be written to 0. Only reset clears it.
- R7: While the lock is engaged, bit 0 of the SMI enable register (address 0x1) keeps its value on writes, and its bits 7..1 stay writable. Before the lock is engaged, all eight bits are writable.
- R8: Each of the eight control bytes (addresses 0x8 to 0xF) stores its written byte and reads it back, and any write in that range re-evaluates the lock.
- R9: The command address reads back the last command byte written.
- R10: Writes to unmapped addresses (0x2 to 0x7) change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 4 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 8 | Combinational read data |
| sci_en | output | 1 | SCI mode active |
| smi_pulse | output | 1 | One-cycle SMI request |

## Verification
A wrong pulse-machine state shows up at `smi_pulse` one cycle after the offending command write. A wrong mode state shows up on `sci_en` in the same cycle. A lock that engages wrongly, or fails to hold, appears as a changed bit 0 at address 0x1, or a cleared bit 4 at address 0x8, on the read immediately after the next write there. Because the reference model is compared against every output on every cycle, a divergence is reported within one cycle of the write that exposes it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_FIRE = 1'b1
    } cmd_state_e;

    typedef enum logic {
        MODE_SMI = 1'b0,
        MODE_SCI = 1'b1
    } mode_state_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SHUT = 1'b1
    } lock_state_e;

endpackage

// File: rtl/pmc_cmd_unit.sv
module pmc_cmd_unit
    import pmc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CODE_ON  = 'hF1,
    parameter int CODE_OFF = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              gate_ok,
    output logic [DATA_W-1:0] last_cmd,
    output logic              sci_en,
    output logic              smi_pulse
);

    localparam logic [DATA_W-1:0] ON_V  = DATA_W'(CODE_ON);
    localparam logic [DATA_W-1:0] OFF_V = DATA_W'(CODE_OFF);

    cmd_state_e  cmd_q, cmd_d;
    mode_state_e mode_q, mode_d;
    logic        is_on, is_off, fire_req;

    assign is_on    = cmd_wr && (cmd_data == ON_V);
    assign is_off   = cmd_wr && (cmd_data == OFF_V);
    assign fire_req = cmd_wr && !(cmd_data == ON_V) && !(cmd_data == OFF_V) && gate_ok;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= CMD_IDLE;
            mode_q   <= MODE_SMI;
            last_cmd <= '0;
        end else begin
            cmd_q  <= cmd_d;
            mode_q <= mode_d;
            if (cmd_wr) begin
                last_cmd <= cmd_data;
            end
        end
    end

    // transitions
    always_comb begin
        cmd_d = cmd_q;
        unique case (cmd_q)
            CMD_IDLE: if (fire_req) cmd_d = CMD_FIRE;
            CMD_FIRE: cmd_d = fire_req ? CMD_FIRE : CMD_IDLE;
            default:  cmd_d = CMD_IDLE;
        endcase
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SMI: if (is_on)  mode_d = MODE_SCI;
            MODE_SCI: if (is_off) mode_d = MODE_SMI;
            default:  mode_d = MODE_SMI;
        endcase
    end

    // outputs
    always_comb begin
        unique case (cmd_q)
            CMD_FIRE: smi_pulse = 1'b1;
            default:  smi_pulse = 1'b0;
        endcase
        unique case (mode_q)
            MODE_SCI: sci_en = 1'b1;
            default:  sci_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmc_smien_reg.sv
module pmc_smien_reg #(
    parameter int DATA_W  = 8,
    parameter int GEN_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    input  logic              locked,
    output logic [DATA_W-1:0] value
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == GEN_BIT) begin : g_guarded
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    value[b] <= 1'b0;
                end else if (wr && !locked) begin
                    value[b] <= data[b];
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    value[b] <= 1'b0;
                end else if (wr) begin
                    value[b] <= data[b];
                end
            end
        end
    end

endmodule

// File: rtl/pmc_ctl_bank.sv
module pmc_ctl_bank
    import pmc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CTRL_BYTES = 8,
    parameter int LOCK_BIT   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [$clog2(CTRL_BYTES)-1:0] widx,
    input  logic [DATA_W-1:0]             data,
    input  logic [$clog2(CTRL_BYTES)-1:0] ridx,
    output logic [DATA_W-1:0]             rd_byte,
    output logic                          locked
);

    localparam int IDX_W = $clog2(CTRL_BYTES);

    logic [DATA_W-1:0] bytes_q [CTRL_BYTES];
    lock_state_e       lk_q, lk_d;
    logic              byte0_lock_img;

    for (genvar i = 0; i < CTRL_BYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bytes_q[i] <= '0;
            end else if (wr && (widx == IDX_W'(i))) begin
                bytes_q[i] <= data;
            end
        end
    end

    // lock bit of byte 0 as it stands after the current write
    assign byte0_lock_img = (widx == '0) ? data[LOCK_BIT] : bytes_q[0][LOCK_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= LK_OPEN;
        end else begin
            lk_q <= lk_d;
        end
    end

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_OPEN: if (wr && byte0_lock_img) lk_d = LK_SHUT;
            LK_SHUT: lk_d = LK_SHUT;
            default: lk_d = LK_OPEN;
        endcase
    end

    always_comb begin
        unique case (lk_q)
            LK_SHUT: locked = 1'b1;
            default: locked = 1'b0;
        endcase
        rd_byte = bytes_q[ridx];
        if (ridx == '0) begin
            rd_byte[LOCK_BIT] = locked;
        end
    end

endmodule

// File: rtl/pmc_smi_port.sv
module pmc_smi_port #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int CMD_ADDR   = 0,
    parameter int SMIEN_ADDR = 1,
    parameter int CTRL_BASE  = 8,
    parameter int CTRL_BYTES = 8,
    parameter int CODE_ON    = 'hF1,
    parameter int CODE_OFF   = 'hF0,
    parameter int GEN_BIT    = 0,
    parameter int CMD_EN_BIT = 5,
    parameter int LOCK_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sci_en,
    output logic              smi_pulse
);

    localparam int IDX_W = $clog2(CTRL_BYTES);

    logic              cmd_wr, smien_wr, ctl_wr, gate_ok, lock_st;
    logic              rd_in_ctl;
    logic [IDX_W-1:0]  ctl_widx, ctl_ridx;
    logic [DATA_W-1:0] last_cmd, smien_q, ctl_rd;

    assign cmd_wr   = wr_en && (int'(wr_addr) == CMD_ADDR);
    assign smien_wr = wr_en && (int'(wr_addr) == SMIEN_ADDR);
    assign ctl_wr   = wr_en && (int'(wr_addr) >= CTRL_BASE)
                            && (int'(wr_addr) < CTRL_BASE + CTRL_BYTES);
    assign ctl_widx = IDX_W'(int'(wr_addr) - CTRL_BASE);
    assign ctl_ridx = IDX_W'(int'(rd_addr) - CTRL_BASE);
    assign rd_in_ctl = (int'(rd_addr) >= CTRL_BASE)
                    && (int'(rd_addr) < CTRL_BASE + CTRL_BYTES);
    assign gate_ok  = smien_q[GEN_BIT] && smien_q[CMD_EN_BIT];

    pmc_cmd_unit #(
        .DATA_W   (DATA_W),
        .CODE_ON  (CODE_ON),
        .CODE_OFF (CODE_OFF)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_data  (wr_data),
        .gate_ok   (gate_ok),
        .last_cmd  (last_cmd),
        .sci_en    (sci_en),
        .smi_pulse (smi_pulse)
    );

    pmc_smien_reg #(
        .DATA_W  (DATA_W),
        .GEN_BIT (GEN_BIT)
    ) u_smien (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (smien_wr),
        .data   (wr_data),
        .locked (lock_st),
        .value  (smien_q)
    );

    pmc_ctl_bank #(
        .DATA_W     (DATA_W),
        .CTRL_BYTES (CTRL_BYTES),
        .LOCK_BIT   (LOCK_BIT)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctl_wr),
        .widx    (ctl_widx),
        .data    (wr_data),
        .ridx    (ctl_ridx),
        .rd_byte (ctl_rd),
        .locked  (lock_st)
    );

    always_comb begin
        if (int'(rd_addr) == CMD_ADDR) begin
            rd_data = last_cmd;
        end else if (int'(rd_addr) == SMIEN_ADDR) begin
            rd_data = smien_q;
        end else if (rd_in_ctl) begin
            rd_data = ctl_rd;
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/pmc_smi_port_chk.sv
module pmc_smi_port_chk #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int CMD_ADDR   = 0,
    parameter int CODE_ON    = 'hF1,
    parameter int CODE_OFF   = 'hF0,
    parameter int GEN_BIT    = 0,
    parameter int CMD_EN_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              sci_en,
    input logic              smi_pulse,
    input logic              locked,
    input logic [DATA_W-1:0] smien
);

    logic c_wr, c_on, c_off, c_other;
    assign c_wr    = wr_en && (int'(wr_addr) == CMD_ADDR);
    assign c_on    = c_wr && (wr_data == DATA_W'(CODE_ON));
    assign c_off   = c_wr && (wr_data == DATA_W'(CODE_OFF));
    assign c_other = c_wr && !c_on && !c_off;

    a_r2_sci_on: assert property (@(posedge clk) disable iff (!rst_n)
        c_on |=> sci_en);
    a_r2_sci_off: assert property (@(posedge clk) disable iff (!rst_n)
        c_off |=> !sci_en);
    a_r2_sci_keep: assert property (@(posedge clk) disable iff (!rst_n)
        c_other |=> $stable(sci_en));
    a_r3_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (c_on || c_off) |=> !smi_pulse);
    a_r4_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(c_other));
    a_r5_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(smien[GEN_BIT] && smien[CMD_EN_BIT]));
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    a_r7_gen_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(smien[GEN_BIT]));

endmodule

bind pmc_smi_port pmc_smi_port_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .CMD_ADDR   (CMD_ADDR),
    .CODE_ON    (CODE_ON),
    .CODE_OFF   (CODE_OFF),
    .GEN_BIT    (GEN_BIT),
    .CMD_EN_BIT (CMD_EN_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sci_en    (sci_en),
    .smi_pulse (smi_pulse),
    .locked    (lock_st),
    .smien     (smien_q)
);

// File: tb/pmc_smi_port_test.sv
`timescale 1ns/1ps
module pmc_smi_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sci_en, smi_pulse;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pmc_smi_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sci_en    (sci_en),
        .smi_pulse (smi_pulse)
    );

    // behavioural reference model
    logic [7:0] m_cmd, m_smien;
    logic [7:0] m_ctl [8];
    bit         m_lock, m_sci, m_pulse;

    function automatic logic [7:0] m_read(input logic [3:0] a);
        logic [7:0] v;
        if (a == 4'h0) return m_cmd;
        if (a == 4'h1) return m_smien;
        if (a >= 4'h8) begin
            v = m_ctl[a - 4'h8];
            if (a == 4'h8) v[4] = m_lock;
            return v;
        end
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cmd = 0; m_smien = 0; m_lock = 0; m_sci = 0; m_pulse = 0;
            for (int i = 0; i < 8; i++) m_ctl[i] = 0;
        end else begin
            m_pulse = 0;
            if (wr_en) begin
                if (wr_addr == 4'h0) begin
                    m_cmd = wr_data;
                    if (wr_data == 8'hF1) m_sci = 1;
                    else if (wr_data == 8'hF0) m_sci = 0;
                    else if (m_smien[0] && m_smien[5]) m_pulse = 1;
                end else if (wr_addr == 4'h1) begin
                    m_smien = m_lock ? {wr_data[7:1], m_smien[0]} : wr_data;
                end else if (wr_addr >= 4'h8) begin
                    m_ctl[wr_addr - 4'h8] = wr_data;
                    if (m_ctl[0][4]) m_lock = 1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!done) begin
            check({cur_req, " model sci_en"}, {7'b0, sci_en}, {7'b0, m_sci});
            check({cur_req, " model smi_pulse"}, {7'b0, smi_pulse}, {7'b0, m_pulse});
            check({cur_req, " model rd_data"}, rd_data, m_read(rd_addr));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        #1;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 sci at reset", {7'b0, sci_en}, 8'h00);
        check("R1 pulse at reset", {7'b0, smi_pulse}, 8'h00);
        rst_n = 1;
        rd("R1 cmd reads 0", 4'h0, 8'h00);
        rd("R1 smien reads 0", 4'h1, 8'h00);
        rd("R1 lock byte reads 0", 4'h8, 8'h00);

        cur_req = "R5";
        wr(4'h0, 8'h55);
        check("R5 no pulse with enables clear", {7'b0, smi_pulse}, 8'h00);
        rd("R9 last command readback", 4'h0, 8'h55);

        wr(4'h1, 8'h20);
        wr(4'h0, 8'h33);
        check("R5 no pulse without global bit", {7'b0, smi_pulse}, 8'h00);
        wr(4'h1, 8'h01);
        wr(4'h0, 8'h33);
        check("R5 no pulse without command bit", {7'b0, smi_pulse}, 8'h00);

        cur_req = "R4";
        wr(4'h1, 8'h21);
        wr(4'h0, 8'h33);
        check("R4 pulse cycle after write", {7'b0, smi_pulse}, 8'h01);
        check("R4 sci unchanged by request", {7'b0, sci_en}, 8'h00);
        @(negedge clk); #1;
        check("R4 pulse lasts one cycle", {7'b0, smi_pulse}, 8'h00);
        wr(4'h0, 8'h10);
        wr(4'h0, 8'h11);
        wr(4'h0, 8'hEF);

        cur_req = "R2";
        wr(4'h0, 8'hF1);
        check("R2 enable code sets sci", {7'b0, sci_en}, 8'h01);
        check("R3 enable code no pulse", {7'b0, smi_pulse}, 8'h00);
        wr(4'h0, 8'h77);
        check("R2 other code keeps sci", {7'b0, sci_en}, 8'h01);
        wr(4'h0, 8'hF0);
        check("R2 disable code clears sci", {7'b0, sci_en}, 8'h00);
        check("R3 disable code no pulse", {7'b0, smi_pulse}, 8'h00);

        cur_req = "R10";
        wr(4'h3, 8'hFF);
        rd("R10 unmapped reads 0", 4'h3, 8'h00);
        rd("R10 smien untouched", 4'h1, 8'h21);

        cur_req = "R8";
        wr(4'hB, 8'hA5);
        rd("R8 control byte readback", 4'hB, 8'hA5);
        wr(4'hF, 8'h3C);
        rd("R8 top control byte", 4'hF, 8'h3C);
        rd("R8 no lock from other byte", 4'h8, 8'h00);
        wr(4'h1, 8'h00);
        rd("R7 bit0 writable while open", 4'h1, 8'h00);

        cur_req = "R6";
        wr(4'h1, 8'h21);
        wr(4'h8, 8'h12);
        rd("R6 lock engaged", 4'h8, 8'h12);
        wr(4'h8, 8'h02);
        rd("R6 lock not clearable", 4'h8, 8'h12);
        cur_req = "R7";
        wr(4'h1, 8'h00);
        rd("R7 bit0 held under lock", 4'h1, 8'h01);
        wr(4'h0, 8'h44);
        check("R7 upper bits writable so no pulse", {7'b0, smi_pulse}, 8'h00);
        wr(4'h1, 8'hE0);
        rd("R7 upper bits written, bit0 held", 4'h1, 8'hE1);
        wr(4'h0, 8'h44);
        check("R4 pulse under lock", {7'b0, smi_pulse}, 8'h01);

        cur_req = "R6";
        @(negedge clk);
        rst_n = 0;
        @(negedge clk); #1;
        check("R1 sci zero in reset", {7'b0, sci_en}, 8'h00);
        rst_n = 1;
        rd("R6 reset clears lock", 4'h8, 8'h00);
        wr(4'h1, 8'h20);
        rd("R6 bit0 writable after reset", 4'h1, 8'h20);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule